// File: doc/BRIEF.md
# Address Space Identifier Allocator with Rollover Flush

This block hands out address space identifiers to new execution contexts so that translation cache entries from different contexts can stay resident side by side. A bitmap records which identifiers are in use. A request is answered one cycle later with the lowest-numbered free identifier, and that identifier is then marked as taken. A release input returns an identifier to the pool.

A request never fails. When every identifier is taken, the block sends out a single-cycle pulse that tells the translation caches to drop all of their entries. In the same step it empties the bitmap. On the next cycle it grants identifier 0 to the waiting request. Each grant also comes with a page-table base register image: the granted identifier sits in the upper bits, and the table root address that was presented with the request fills the lower bits.

Top module: `asid_alloc`

## Requirements
- R1: After reset, no grant or flush is signalled and every identifier is free, so the first request is granted identifier 0.
- R2: A request sampled at a clock edge produces, after the next edge, a grant valid pulse lasting one cycle, together with the lowest-numbered free identifier.
- R3: A granted identifier is marked used and is not granted again until it has been released.
- R4: A release frees the named identifier, so a later request can receive it again.
- R5: When a request and a release arrive in the same cycle, both take effect, and the identifier being released is not the one granted for that request.
- R6: A request that finds no free identifier raises the flush output for exactly one cycle, starting one cycle after the request, with no grant in that cycle.
- R7: In the cycle after a flush pulse, the pending request is granted identifier 0, and 0 is then the only identifier in use.
- R8: While a grant is valid, the base register image carries the granted identifier in its top ASID_W bits and, in the bits below, the root address sampled with the request.
- R9: A request asserted during the flush cycle is ignored and produces no grant.
- R10: A release with no request produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request a new identifier |
| root_i | input | PTBR_W-ASID_W | Table root address sampled with the request |
| rel_i | input | 1 | Release an identifier |
| rel_asid_i | input | ASID_W | Identifier to release |
| grant_valid_o | output | 1 | One-cycle grant strobe |
| grant_asid_o | output | ASID_W | Granted identifier |
| ptbr_o | output | PTBR_W | Base register image: identifier in top bits, root below |
| flush_all_o | output | 1 | One-cycle pulse to invalidate all translation entries |

## Verification
The hardest condition to reach from the ports is rollover, because it happens only when every identifier is taken at once. The bench uses a 3-bit identifier so that eight grants fill the pool. It then requests once more and checks that the flush pulse comes first and the grant of 0 follows. It fills the pool a second time and holds the request high through the flush cycle, which shows that the extra request is dropped.

// File: rtl/asid_pkg.sv
package asid_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } alloc_state_e;

    // Identifier handed out right after a rollover.
    localparam int unsigned ROLLOVER_ID = 0;

endpackage

// File: rtl/asid_used_map.sv
module asid_used_map #(
    parameter int unsigned ASID_W = 8,
    localparam int unsigned ASID_N = 1 << ASID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              set_en_i,
    input  logic [ASID_W-1:0] set_idx_i,
    input  logic              rel_en_i,
    input  logic [ASID_W-1:0] rel_idx_i,
    output logic [ASID_N-1:0] used_o
);

    // One flop per identifier. A set beats a release, and a clear beats both.
    for (genvar g = 0; g < ASID_N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                used_o[g] <= 1'b0;
            end else if (set_en_i && (set_idx_i == ASID_W'(g))) begin
                used_o[g] <= 1'b1;
            end else if (rel_en_i && (rel_idx_i == ASID_W'(g))) begin
                used_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/asid_lowest_free.sv
module asid_lowest_free #(
    parameter int unsigned ASID_W = 8,
    localparam int unsigned ASID_N = 1 << ASID_W
) (
    input  logic [ASID_N-1:0] used_i,
    output logic              found_o,
    output logic [ASID_W-1:0] idx_o
);

    // Scan from high to low so that the lowest free index is the last one written.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = ASID_N - 1; i >= 0; i--) begin
            if (!used_i[i]) begin
                found_o = 1'b1;
                idx_o   = ASID_W'(i);
            end
        end
    end

endmodule

// File: rtl/asid_alloc_ctrl.sv
module asid_alloc_ctrl
    import asid_pkg::*;
#(
    parameter int unsigned ASID_W = 8,
    parameter int unsigned ROOT_W = 56
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic              found_i,
    input  logic [ASID_W-1:0] found_idx_i,
    output logic              clr_o,
    output logic              set_en_o,
    output logic [ASID_W-1:0] set_idx_o,
    output logic              grant_valid_o,
    output logic [ASID_W-1:0] grant_asid_o,
    output logic [ROOT_W-1:0] root_o,
    output logic              flush_o
);

    alloc_state_e state_q;

    // Update the bitmap in the same edge that registers the grant.
    always_comb begin
        clr_o     = 1'b0;
        set_en_o  = 1'b0;
        set_idx_o = found_idx_i;
        if (state_q == ST_FLUSH) begin
            set_en_o  = 1'b1;
            set_idx_o = ASID_W'(ROLLOVER_ID);
        end else if (req_i) begin
            if (found_i) set_en_o = 1'b1;
            else         clr_o    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_RUN;
            grant_valid_o <= 1'b0;
            grant_asid_o  <= '0;
            root_o        <= '0;
            flush_o       <= 1'b0;
        end else begin
            grant_valid_o <= 1'b0;
            flush_o       <= 1'b0;
            if (state_q == ST_FLUSH) begin
                state_q       <= ST_RUN;
                grant_valid_o <= 1'b1;
                grant_asid_o  <= ASID_W'(ROLLOVER_ID);
            end else if (req_i) begin
                root_o <= root_i;
                if (found_i) begin
                    grant_valid_o <= 1'b1;
                    grant_asid_o  <= found_idx_i;
                end else begin
                    state_q <= ST_FLUSH;
                    flush_o <= 1'b1;
                end
            end
        end
    end

    // R6
    flush_single_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);

    // R6
    flush_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> !grant_valid_o);

    // R7
    rollover_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> (grant_valid_o && grant_asid_o == ASID_W'(ROLLOVER_ID)));

    // R10
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid_o && !$past(flush_o)) |-> $past(req_i));

endmodule

// File: rtl/asid_alloc.sv
module asid_alloc #(
    parameter int unsigned ASID_W = 8,
    parameter int unsigned PTBR_W = 64,
    localparam int unsigned ROOT_W = PTBR_W - ASID_W,
    localparam int unsigned ASID_N = 1 << ASID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ROOT_W-1:0] root_i,
    input  logic              rel_i,
    input  logic [ASID_W-1:0] rel_asid_i,
    output logic              grant_valid_o,
    output logic [ASID_W-1:0] grant_asid_o,
    output logic [PTBR_W-1:0] ptbr_o,
    output logic              flush_all_o
);

    logic [ASID_N-1:0] used;
    logic              found;
    logic [ASID_W-1:0] found_idx;
    logic              clr, set_en;
    logic [ASID_W-1:0] set_idx;
    logic [ROOT_W-1:0] root_q;

    asid_used_map #(.ASID_W(ASID_W)) u_map (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .set_en_i  (set_en),
        .set_idx_i (set_idx),
        .rel_en_i  (rel_i),
        .rel_idx_i (rel_asid_i),
        .used_o    (used)
    );

    asid_lowest_free #(.ASID_W(ASID_W)) u_find (
        .used_i  (used),
        .found_o (found),
        .idx_o   (found_idx)
    );

    asid_alloc_ctrl #(.ASID_W(ASID_W), .ROOT_W(ROOT_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req_i),
        .root_i        (root_i),
        .found_i       (found),
        .found_idx_i   (found_idx),
        .clr_o         (clr),
        .set_en_o      (set_en),
        .set_idx_o     (set_idx),
        .grant_valid_o (grant_valid_o),
        .grant_asid_o  (grant_asid_o),
        .root_o        (root_q),
        .flush_o       (flush_all_o)
    );

    assign ptbr_o = {grant_asid_o, root_q};

    // R3
    granted_marked_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |-> used[grant_asid_o]);

    // R7
    rollover_sole_chk: assert property (@(posedge clk) disable iff (rst)
        flush_all_o |=> ($countones(used) == 1 && used[0]));

endmodule

// File: tb/asid_alloc_tb.sv
module asid_alloc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int PW = 16;
    localparam int RW = PW - AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req;
    logic [RW-1:0] root;
    logic          rel;
    logic [AW-1:0] rel_id;
    logic          gv;
    logic [AW-1:0] gid;
    logic [PW-1:0] ptbr;
    logic          flush;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_alloc #(.ASID_W(AW), .PTBR_W(PW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_i         (req),
        .root_i        (root),
        .rel_i         (rel),
        .rel_asid_i    (rel_id),
        .grant_valid_o (gv),
        .grant_asid_o  (gid),
        .ptbr_o        (ptbr),
        .flush_all_o   (flush)
    );

    typedef struct packed {
        logic          req;
        logic          rel;
        logic [AW-1:0] rid;
        logic          ev;
        logic [AW-1:0] eid;
        logic          ef;
    } vec_t;

    // Each row is applied for one cycle, and the outputs are checked one cycle later.
    localparam vec_t VEC [0:13] = '{
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0},  // R1 first grant is 0
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0},  // R2
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0},  // R2
        '{1'b1, 1'b1, 3'd1, 1'b1, 3'd3, 1'b0},  // R5 releasing 1 does not give 1
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0},  // R4 1 is free again
        '{1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0},  // R10 release only
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0},  // R4
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd4, 1'b0},  // R3
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0},  // R3
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd6, 1'b0},  // R3
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd7, 1'b0},  // R3 pool full now
        '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1},  // R6 flush pulse
        '{1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0},  // R7 grant 0
        '{1'b1, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0}   // R7 only 0 was used
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic [AW-1:0] id,
                        input logic [RW-1:0] rt);
        req = r; rel = l; rel_id = id; root = rt;
        @(negedge clk);
    endtask

    initial begin
        logic [RW-1:0] last_root;
        rst = 1'b1; req = 1'b0; rel = 1'b0; rel_id = '0; root = '0;
        last_root = '0;
        repeat (3) @(negedge clk);
        chk("R1 grant after reset", 32'(gv), 32'd0);
        chk("R1 flush after reset", 32'(flush), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 14; i++) begin
            logic [RW-1:0] rt;
            rt = RW'(13'h0A0 + i);
            if (VEC[i].req) last_root = rt;
            step(VEC[i].req, VEC[i].rel, VEC[i].rid, rt);
            chk($sformatf("R2 valid row %0d", i), 32'(gv), 32'(VEC[i].ev));
            chk($sformatf("R6 flush row %0d", i), 32'(flush), 32'(VEC[i].ef));
            if (VEC[i].ev) begin
                chk($sformatf("R2 asid row %0d", i), 32'(gid), 32'(VEC[i].eid));
                chk($sformatf("R8 ptbr row %0d", i), 32'(ptbr), 32'({VEC[i].eid, last_root}));
            end
        end

        // Pool holds {0,1}: fill 2..7 again.
        for (int k = 2; k < 8; k++) begin
            step(1'b1, 1'b0, '0, RW'(k));
            chk("R3 refill", 32'(gid), 32'(k));
        end
        // R9: hold the request through the flush cycle.
        step(1'b1, 1'b0, '0, RW'(13'h1234));
        chk("R6 second flush", 32'(flush), 32'd1);
        step(1'b1, 1'b0, '0, RW'(13'h0777));
        chk("R7 grant zero", 32'(gv && gid == 0), 32'd1);
        chk("R8 root from flush request", 32'(ptbr), 32'({3'd0, 13'h1234}));
        step(1'b0, 1'b0, '0, '0);
        chk("R9 request in flush cycle dropped", 32'(gv), 32'd0);
        step(1'b1, 1'b0, '0, '0);
        chk("R9 next id is 1", 32'(gid), 32'd1);

        // R1: reset in the middle of a run empties the pool.
        rst = 1'b1;
        step(1'b0, 1'b0, '0, '0);
        rst = 1'b0;
        step(1'b1, 1'b0, '0, '0);
        chk("R1 after mid-run reset", 32'(gv && gid == 0), 32'd1);
        step(1'b0, 1'b0, '0, '0);
        chk("R2 valid is one cycle", 32'(gv), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule